// File: doc/BRIEF.md
# Indexed Extension Word Decoder

This block turns the extension words that follow an indexed addressing-mode opcode into a ready-to-use operand descriptor. A controller pulses `start` together with the base selector and the mode flag. The selector names an address register, or the program counter when no address register is supplied. The block then takes 16-bit words from a stream, one per cycle in which `word_valid` is high. The first word is the index extension word. It says which index register is used, at what size and scale, and whether further displacement words follow.

Two encodings are accepted. In the short encoding, bit 8 of the extension word is clear and the word carries an 8-bit displacement. In the long encoding, bit 8 is set and the base and index can each be dropped. A base displacement and an outer displacement of zero, one or two words may follow in the stream, base first. Three address forms are named. When the `legacy` flag is set, every extension word is read in the short encoding with the scale forced to 0. The block does no address arithmetic and no memory reads. It only reports what the words say and how many of them it took.

Top module: `ixd_decoder`

## Requirements
- R1: `start` is accepted only while idle; `base_is_pc`, `base_reg` and `legacy` are captured at that moment. `idx_is_addr` = word bit 15 (1 = address register), `idx_num` = bits 14:12, `idx_long` = bit 11 (1 = long), and outside legacy mode `idx_scale` = bits 10:9.
- R2: With `legacy` captured high, or with bit 8 clear, the short encoding applies: `base_disp` = bits 7:0 sign-extended to 32 bits, `outer_disp` = 0, form 0, one word taken. With `legacy` high, `idx_scale` is 0 whatever bits 10:9 and bit 8 hold.
- R3: `base_kind` is 2 (none) when the long encoding has bit 7 set. Otherwise it is 1 (program counter) if `base_is_pc` was captured high, else 0 (address register `base_num`). `idx_on` is 0 only when the long encoding has bit 6 set.
- R4: In the long encoding, bits 5:4 give the base displacement length: 00 or 01 = none (value 0), 10 = one word sign-extended, 11 = two words, the first word taken being the upper half.
- R5: Bits 1:0 give the outer displacement length with the same code. Its words are taken after all base displacement words.
- R6: `form` is 0 (register offset) when bits 2:0 are 000 or the short encoding applies. Otherwise it is 1 (memory, index before indirection) when bit 2 is clear and 2 (memory, index after indirection) when bit 2 is set.
- R7: `words_used` equals 1 plus the base and outer displacement word counts, and lies between 1 and 5.
- R8: Words are taken only in cycles with `word_valid` high while a decode is in progress. Words offered while idle, and `start` pulses while busy, have no effect.
- R9: `done` is high for exactly one cycle, the cycle after the edge that takes the last word. The descriptor outputs then hold until the next accepted `start`.
- R10: After reset, `done` is 0, `words_used` is 0 and both displacements are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decode (accepted while idle) |
| base_is_pc | input | 1 | Base is the program counter rather than an address register |
| base_reg | input | 3 | Address register number used as the base |
| legacy | input | 1 | Force short-encoding interpretation |
| word_valid | input | 1 | `word_in` carries the next stream word |
| word_in | input | 16 | Stream word |
| done | output | 1 | Descriptor complete (one-cycle pulse) |
| base_kind | output | 2 | 0 address register, 1 program counter, 2 none |
| base_num | output | 3 | Captured base register number |
| idx_on | output | 1 | Index register in use |
| idx_is_addr | output | 1 | Index is an address register |
| idx_num | output | 3 | Index register number |
| idx_long | output | 1 | Index used at long size |
| idx_scale | output | 2 | Index scale code |
| base_disp | output | 32 | Base displacement |
| outer_disp | output | 32 | Outer displacement |
| form | output | 2 | 0 register offset, 1 memory pre-indexed, 2 memory post-indexed |
| words_used | output | 3 | Words taken for this descriptor |

## Verification
The embedded properties check on every cycle the invariants that hold whatever the stream content. These are: the single-cycle `done` pulse, the 1 to 5 range of the word count, the freeze of progress while `word_valid` is low, the hold of the descriptor while idle, the restrictions that legacy mode puts on the result, and the order in which the halves of a two-word displacement are filled. Whether each field carries the value the extension word asks for can only be shown by the bench. It sweeps every low byte against both encodings, all scale codes, both modes and two register patterns. Its scenarios also show that the captured selector wins over later input changes, and that stray words and `start` pulses are ignored.

// File: rtl/ixd_pkg.sv
package ixd_pkg;

    localparam int WORD_W = 16;
    localparam int DISP_W = 32;
    localparam int REG_W  = 3;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        BK_AREG = 2'd0,
        BK_PC   = 2'd1,
        BK_NONE = 2'd2
    } base_kind_e;

    typedef enum logic [1:0] {
        FM_REG_OFS  = 2'd0,
        FM_MEM_PRE  = 2'd1,
        FM_MEM_POST = 2'd2
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXT  = 2'd1,
        ST_BD   = 2'd2,
        ST_OD   = 2'd3
    } step_e;

    // Descriptor fields kept after the extension word is taken
    typedef struct packed {
        logic             idx_addr;
        logic [REG_W-1:0] idx_num;
        logic             idx_long;
        logic [1:0]       idx_scale;
        logic             base_sup;
        logic             idx_sup;
        logic [1:0]       bd_len;
        logic [1:0]       od_len;
        form_e            form;
    } ext_fields_t;

    // Displacement length code: 0x -> no word, 10 -> one, 11 -> two
    function automatic logic [1:0] disp_len(input logic [1:0] code);
        return code[1] ? (code[0] ? 2'd2 : 2'd1) : 2'd0;
    endfunction

    function automatic form_e form_of(input logic [2:0] sel);
        if (sel == 3'b000) return FM_REG_OFS;
        return sel[2] ? FM_MEM_POST : FM_MEM_PRE;
    endfunction

    function automatic logic [DISP_W-1:0] sext8(input logic [7:0] b);
        return {{(DISP_W-8){b[7]}}, b};
    endfunction

    function automatic logic [DISP_W-1:0] sext16(input logic [WORD_W-1:0] w);
        return {{(DISP_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

endpackage

// File: rtl/ixd_field_decode.sv
module ixd_field_decode
    import ixd_pkg::*;
(
    input  logic [WORD_W-1:0] ext,
    input  logic              legacy,
    output ext_fields_t       fields,
    output logic              brief,
    output logic [DISP_W-1:0] short_disp
);

    always_comb begin
        brief      = legacy || !ext[8];
        short_disp = sext8(ext[7:0]);

        fields.idx_addr  = ext[15];
        fields.idx_num   = ext[14:12];
        fields.idx_long  = ext[11];
        fields.idx_scale = legacy ? 2'd0 : ext[10:9];

        if (brief) begin
            fields.base_sup = 1'b0;
            fields.idx_sup  = 1'b0;
            fields.bd_len   = 2'd0;
            fields.od_len   = 2'd0;
            fields.form     = FM_REG_OFS;
        end else begin
            fields.base_sup = ext[7];
            fields.idx_sup  = ext[6];
            fields.bd_len   = disp_len(ext[5:4]);
            fields.od_len   = disp_len(ext[1:0]);
            fields.form     = form_of(ext[2:0]);
        end
    end

endmodule

// File: rtl/ixd_disp_slot.sv
module ixd_disp_slot
    import ixd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [DISP_W-1:0] load_val,
    input  logic              take,
    input  logic              wide,
    input  logic              second,
    input  logic [WORD_W-1:0] word,
    output logic [DISP_W-1:0] val
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (take) begin
            if (!wide)
                val <= sext16(word);
            else if (!second)
                val[DISP_W-1:WORD_W] <= word;
            else
                val[WORD_W-1:0] <= word;
        end
    end

    // Second word of a two-word value fills only the low half (R4)
    p_wide_low_half_r4: assert property (@(posedge clk) disable iff (rst)
        (take && wide && second && !clr && !load)
            |=> (val[DISP_W-1:WORD_W] == $past(val[DISP_W-1:WORD_W])));

endmodule

// File: rtl/ixd_decoder.sv
module ixd_decoder
    import ixd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              base_is_pc,
    input  logic [REG_W-1:0]  base_reg,
    input  logic              legacy,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              done,
    output logic [1:0]        base_kind,
    output logic [REG_W-1:0]  base_num,
    output logic              idx_on,
    output logic              idx_is_addr,
    output logic [REG_W-1:0]  idx_num,
    output logic              idx_long,
    output logic [1:0]        idx_scale,
    output logic [DISP_W-1:0] base_disp,
    output logic [DISP_W-1:0] outer_disp,
    output logic [1:0]        form,
    output logic [CNT_W-1:0]  words_used
);

    localparam int NSLOT = 2;

    step_e             step;
    logic              leg_q, pc_q, phase, done_q;
    logic [REG_W-1:0]  breg_q;
    logic [CNT_W-1:0]  cnt;
    ext_fields_t       fields_q, f_now;
    logic              f_brief;
    logic [DISP_W-1:0] f_short;
    logic              start_acc, ext_take;
    logic [DISP_W-1:0] slot_val [NSLOT];
    logic [1:0]        slot_len [NSLOT];

    assign start_acc = start && (step == ST_IDLE);
    assign ext_take  = word_valid && (step == ST_EXT);
    assign slot_len[0] = fields_q.bd_len;
    assign slot_len[1] = fields_q.od_len;

    ixd_field_decode u_fields (
        .ext        (word_in),
        .legacy     (leg_q),
        .fields     (f_now),
        .brief      (f_brief),
        .short_disp (f_short)
    );

    // Slot 0 gathers the base displacement, slot 1 the outer one
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam step_e OWN_STEP = (g == 0) ? ST_BD : ST_OD;
        ixd_disp_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .clr      (start_acc),
            .load     ((g == 0) && ext_take && f_brief),
            .load_val (f_short),
            .take     (word_valid && (step == OWN_STEP)),
            .wide     (slot_len[g] == 2'd2),
            .second   (phase),
            .word     (word_in),
            .val      (slot_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_IDLE;
            leg_q    <= 1'b0;
            pc_q     <= 1'b0;
            breg_q   <= '0;
            fields_q <= '0;
            phase    <= 1'b0;
            cnt      <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (step)
                ST_IDLE: if (start) begin
                    leg_q    <= legacy;
                    pc_q     <= base_is_pc;
                    breg_q   <= base_reg;
                    fields_q <= '0;
                    cnt      <= '0;
                    phase    <= 1'b0;
                    step     <= ST_EXT;
                end
                ST_EXT: if (word_valid) begin
                    fields_q <= f_now;
                    cnt      <= CNT_W'(1);
                    phase    <= 1'b0;
                    if (f_now.bd_len != 2'd0)      step <= ST_BD;
                    else if (f_now.od_len != 2'd0) step <= ST_OD;
                    else begin
                        step   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                ST_BD: if (word_valid) begin
                    cnt <= cnt + CNT_W'(1);
                    if (phase || fields_q.bd_len == 2'd1) begin
                        phase <= 1'b0;
                        if (fields_q.od_len != 2'd0) step <= ST_OD;
                        else begin
                            step   <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end else begin
                        phase <= 1'b1;
                    end
                end
                ST_OD: if (word_valid) begin
                    cnt <= cnt + CNT_W'(1);
                    if (phase || fields_q.od_len == 2'd1) begin
                        phase  <= 1'b0;
                        step   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        phase <= 1'b1;
                    end
                end
                default: step <= ST_IDLE;
            endcase
        end
    end

    assign done        = done_q;
    assign base_kind   = fields_q.base_sup ? BK_NONE : (pc_q ? BK_PC : BK_AREG);
    assign base_num    = breg_q;
    assign idx_on      = !fields_q.idx_sup;
    assign idx_is_addr = fields_q.idx_addr;
    assign idx_num     = fields_q.idx_num;
    assign idx_long    = fields_q.idx_long;
    assign idx_scale   = fields_q.idx_scale;
    assign base_disp   = slot_val[0];
    assign outer_disp  = slot_val[1];
    assign form        = fields_q.form;
    assign words_used  = cnt;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_words_range_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (words_used >= CNT_W'(1) && words_used <= CNT_W'(5)));

    p_legacy_short_r2: assert property (@(posedge clk) disable iff (rst)
        (done && leg_q) |-> (words_used == CNT_W'(1) && idx_scale == 2'd0
                             && form == FM_REG_OFS && outer_disp == '0));

    p_legacy_keeps_base_r3: assert property (@(posedge clk) disable iff (rst)
        (done && leg_q) |-> (base_kind != BK_NONE && idx_on));

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (step != ST_IDLE && !word_valid) |=> ($stable(words_used) && !done));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (step == ST_IDLE && !start) |=> ($stable(base_disp) && $stable(outer_disp)
                                         && $stable(words_used) && $stable(form)));

endmodule

// File: tb/ixd_decoder_bench.sv
module ixd_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, base_is_pc = 1'b0, legacy = 1'b0, word_valid = 1'b0;
    logic [2:0]  base_reg = '0;
    logic [15:0] word_in = '0;
    logic        done, idx_on, idx_is_addr, idx_long;
    logic [1:0]  base_kind, idx_scale, form;
    logic [2:0]  base_num, idx_num, words_used;
    logic [31:0] base_disp, outer_disp;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ixd_decoder u_ixd_decoder (
        .clk(clk), .rst(rst), .start(start), .base_is_pc(base_is_pc),
        .base_reg(base_reg), .legacy(legacy), .word_valid(word_valid),
        .word_in(word_in), .done(done), .base_kind(base_kind),
        .base_num(base_num), .idx_on(idx_on), .idx_is_addr(idx_is_addr),
        .idx_num(idx_num), .idx_long(idx_long), .idx_scale(idx_scale),
        .base_disp(base_disp), .outer_disp(outer_disp), .form(form),
        .words_used(words_used)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] code);
        return code[1] ? (code[0] ? 2 : 1) : 0;
    endfunction

    function automatic logic [31:0] gather(input int n, input logic [15:0] hi, input logic [15:0] lo);
        if (n == 0) return 32'd0;
        if (n == 1) return {{16{hi[15]}}, hi};
        return {hi, lo};
    endfunction

    task automatic run_case(input int run, input logic [15:0] ext, input logic lg,
                            input logic pc, input logic [2:0] areg);
        logic [15:0] w [5];
        logic        brief, early;
        int          nb, no, n;
        logic [31:0] e_bd, e_od, s_bd, s_od;
        logic [1:0]  e_kind, e_form, e_scale;
        logic [2:0]  s_words;

        brief = lg || !ext[8];
        nb = brief ? 0 : len_of(ext[5:4]);
        no = brief ? 0 : len_of(ext[1:0]);
        n  = 1 + nb + no;
        w[0] = ext;
        for (int i = 1; i < 5; i++)
            w[i] = 16'((run * 37 + i * 4093) ^ 16'hA5C3);
        e_bd    = brief ? {{24{ext[7]}}, ext[7:0]} : gather(nb, w[1], w[2]);
        e_od    = gather(no, w[1+nb], w[2+nb]);
        e_kind  = (!brief && ext[7]) ? 2'd2 : (pc ? 2'd1 : 2'd0);
        e_form  = (brief || ext[2:0] == 3'b000) ? 2'd0 : (ext[2] ? 2'd2 : 2'd1);
        e_scale = lg ? 2'd0 : ext[10:9];

        @(negedge clk);
        start = 1'b1; base_is_pc = pc; base_reg = areg; legacy = lg;
        word_valid = (run % 7 == 0);
        word_in = 16'hFFFF;
        early = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0; word_valid = 1'b0;
            base_is_pc = ~pc; base_reg = ~areg; legacy = ~lg;
            if ((run + i) % 3 == 0) begin
                start = (run % 5 == 0);
                @(negedge clk);
                start = 1'b0;
            end
            if (done) early = 1'b1;
            word_in = w[i];
            word_valid = 1'b1;
        end
        @(negedge clk);
        word_valid = 1'b0;
        check("R8 done before last word", {31'd0, early}, 32'd0);
        check("R9 done after last word", {31'd0, done}, 32'd1);
        check("R1 index kind/number/size", {28'd0, idx_is_addr, idx_num, idx_long},
              {28'd0, ext[15], ext[14:12], ext[11]});
        check("R2 scale code", {30'd0, idx_scale}, {30'd0, e_scale});
        check("R3 base kind", {30'd0, base_kind}, {30'd0, e_kind});
        check("R1 base number captured", {29'd0, base_num}, {29'd0, areg});
        check("R3 index in use", {31'd0, idx_on}, {31'd0, brief || !ext[6]});
        check("R4 base displacement", base_disp, e_bd);
        check("R5 outer displacement", outer_disp, e_od);
        check("R6 form", {30'd0, form}, {30'd0, e_form});
        check("R7 words used", {29'd0, words_used}, 32'(n));
        s_bd = base_disp; s_od = outer_disp; s_words = words_used;
        @(negedge clk);
        check("R9 done pulse ends", {31'd0, done}, 32'd0);
        check("R9 descriptor holds", base_disp ^ s_bd ^ outer_disp ^ s_od, 32'd0);
        check("R9 count holds", {29'd0, words_used}, {29'd0, s_words});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int run;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset done", {31'd0, done}, 32'd0);
        check("R10 reset count", {29'd0, words_used}, 32'd0);
        check("R10 reset displacements", base_disp | outer_disp, 32'd0);
        run = 0;
        for (int lg = 0; lg < 2; lg++)
            for (int up = 0; up < 2; up++)
                for (int sc = 0; sc < 4; sc++)
                    for (int b8 = 0; b8 < 2; b8++)
                        for (int lo = 0; lo < 256; lo++) begin
                            logic [15:0] ext;
                            ext = {(up != 0) ? 5'b10110 : 5'b01011, 2'(sc), 1'(b8), 8'(lo)};
                            run_case(run, ext, 1'(lg), 1'(lo[0] ^ up[0]), 3'(lo >> 1));
                            run++;
                        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule